// File: doc/BRIEF.md
# Eight-bit CPU arithmetic execution unit

This unit carries out the arithmetic operations of a small 8-bit processor. It is given an operation code, a byte/word size select, a destination operand, a register source operand, an 8-bit immediate with a flag that picks it as the second operand, and the carry and half-carry bits of the condition register. It returns a 16-bit result and a five-bit flag set. Each operation is issued with a one-cycle `start`.

All operations except divide finish one clock after they are issued. Divide is a restoring shift-subtract that produces one quotient bit per clock. It raises `busy` while it runs and ends with a `done` pulse.

The unit also checks the operand and size rules of the instruction set. An issued combination that breaks those rules returns an `err` pulse and leaves the result and the flags as they were. The register file and the instruction decoder sit outside this unit. The decoder presents the operands, and it writes back `result` and `flags` when `done` is high.

Top module: `alu8_exec`

## Requirements
- R1: An illegal issue pulses `err` together with `done` and leaves `result` and `flags` unchanged. The illegal issues are:
  - subtract (op 1) with the immediate;
  - add (op 0) or compare (op 12) with `wsize`=1 and the immediate;
  - byte-only ops (2, 3, 4, 5, 8, 9, 13) with `wsize`=1;
  - word adjust (ops 6, 7) without the immediate, or with an immediate other than 1 or 2;
  - multiply or divide (ops 10, 11) with the immediate;
  - op codes 14 and 15.
- R2: Add (op 0) and subtract (op 1) work on bytes (`wsize`=0, low bytes, result zero-extended) or on words (`wsize`=1). They set the flags as follows (bit positions in `flags`):
  - flags[4] N: the sign bit of the result;
  - flags[3] Z: result is zero;
  - flags[2] V: two's-complement overflow;
  - flags[1] C: carry out of the top bit, or borrow into it;
  - flags[0] H: carry or borrow at bit 3 for bytes, at bit 11 for words.
- R3: Add with carry (op 2) and subtract with borrow (op 3) are byte operations. They fold `c_in` into the sum or difference, take `rs` or the immediate, and set all five flags.
- R4: Increment (op 4) and decrement (op 5) change the low byte of `rd` by one. They update N, Z and V and keep C and H.
- R5: Word adjust add (op 6) and subtract (op 7) return `rd` plus or minus the immediate, modulo 2^16. They leave all flags unchanged.
- R6: Decimal adjust is op 8 after an add and op 9 after a subtract. It adds 0x06 (op 9 subtracts it) when the low nibble of `rd` is above 9 or `h_in` is set. It adds 0x60 (op 9 subtracts it) when the byte is above 0x99 or `c_in` is set. C is set exactly when the 0x60 correction applies. N and Z follow the result, and V and H are kept.
- R7: Multiply (op 10) returns the 16-bit unsigned product of the low bytes of `rd` and `rs`, with the flags unchanged.
- R8: Divide (op 11) divides the 16-bit `rd` by the low byte of `rs`. It returns the quotient in result[15:8] and the remainder in result[7:0], sets N and Z from the quotient and clears V. `busy` is high for the 9 cycles after the issue edge, and `done` rises 10 cycles after it.
- R9: Divide with a zero divisor, or with `rd[15:8]` at least the divisor (quotient overflow), sets V and leaves `result` and the other flags unchanged. Its `done` rises 2 cycles after the issue edge.
- R10: Compare (op 12) sets the flags exactly as subtract does, for byte or word size, and leaves `result` unchanged.
- R11: Negate (op 13) returns 0 minus the low byte of `rd`. It sets N, Z and V, sets C when the operand is nonzero, and keeps H.
- R12: Reset clears `result`, `flags`, `done`, `err` and `busy`. Every operation other than divide updates its outputs at the clock after the issue edge, with a one-cycle `done`. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue the operation on the inputs this cycle |
| op | input | 4 | Operation code (0 to 13) |
| wsize | input | 1 | 1 selects word size |
| use_imm | input | 1 | 1 selects the immediate as second operand |
| rd | input | 16 | Destination / first operand |
| rs | input | 16 | Register source operand |
| imm | input | 8 | Immediate operand |
| c_in | input | 1 | Carry from the condition register |
| h_in | input | 1 | Half-carry from the condition register |
| result | output | 16 | Registered result |
| flags | output | 5 | Registered N, Z, V, C, H (bits 4 to 0) |
| err | output | 1 | One-cycle pulse for an illegal issue |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Divide in progress; start is ignored |

## Verification
Add and subtract are tried with operands chosen to make each flag matter: a byte sum that carries at bit 3 and overflows, a wrap to zero, a word carry at bit 11 alone, a byte borrow, and a word signed overflow. Carry-in folding is told apart from a plain add by issuing the same operands with `c_in` set. Divide is run with a quotient that fits, a dividend high byte just below the divisor, a zero divisor, and an overflowing high byte; the two failing cases differ from a good one in latency as well as in V. Every rule-breaking operand combination is issued after a known result, so that a changed output shows.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBC = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_WADD = 4'd6,
    OP_WSUB = 4'd7,
    OP_DAA  = 4'd8,
    OP_DAS  = 4'd9,
    OP_MUL  = 4'd10,
    OP_DIV  = 4'd11,
    OP_CMP  = 4'd12,
    OP_NEG  = 4'd13
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic h;
  } flags_t;

endpackage

// File: rtl/alu8_legal.sv
module alu8_legal
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           opc,
  input  logic          wsize,
  input  logic          use_imm,
  input  logic [DW-1:0] imm,
  output logic          ok
);

  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] TWO = DW'(2);

  always_comb begin
    case (opc)
      OP_ADD, OP_CMP: ok = !(wsize && use_imm);
      OP_SUB:         ok = !use_imm;
      OP_ADDC, OP_SUBC, OP_INC, OP_DEC,
      OP_DAA, OP_DAS, OP_NEG:
                      ok = !wsize;
      OP_WADD, OP_WSUB:
                      ok = use_imm && (imm == ONE || imm == TWO);
      OP_MUL, OP_DIV: ok = !use_imm;
      default:        ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);

  localparam int LOW = W - 4;

  logic [W:0]   full;
  logic [LOW:0] part;

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ci};
      part = {1'b0, x[LOW-1:0]} - {1'b0, y[LOW-1:0]} - {{LOW{1'b0}}, ci};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
      part = {1'b0, x[LOW-1:0]} + {1'b0, y[LOW-1:0]} + {{LOW{1'b0}}, ci};
    end
    r   = full[W-1:0];
    c_o = full[W];
    h_o = part[LOW];
    if (sub) v_o = (x[W-1] != y[W-1]) && (full[W-1] != x[W-1]);
    else     v_o = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
  end

endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] v,
  input  logic          c_in,
  input  logic          h_in,
  input  logic          sub,
  output logic [DW-1:0] r,
  output logic          c_o
);

  logic          lo_fix;
  logic          hi_fix;
  logic [DW-1:0] adj;

  always_comb begin
    lo_fix = (v[3:0] > 4'd9) || h_in;
    hi_fix = (v > DW'(8'h99)) || c_in;
    adj    = {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
    r      = sub ? (v - adj) : (v + adj);
    c_o    = hi_fix;
  end

endmodule

// File: rtl/alu8_div.sv
module alu8_div #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2*DW-1:0] dvd,
  input  logic [DW-1:0]   dvs,
  output logic            busy,
  output logic            done,
  output logic            ovf,
  output logic [DW-1:0]   quo,
  output logic [DW-1:0]   rem
);

  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] dsr;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          ge;

  assign trial = {rem, quo[DW-1]};
  assign ge    = trial >= {1'b0, dsr};
  assign diff  = trial - {1'b0, dsr};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      ovf  <= 1'b0;
      cnt  <= '0;
      dsr  <= '0;
      quo  <= '0;
      rem  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dsr <= dvs;
        rem <= dvd[2*DW-1:DW];
        quo <= dvd[DW-1:0];
        if (dvd[2*DW-1:DW] >= dvs) begin
          ovf  <= 1'b1;
          done <= 1'b1;
        end else begin
          ovf  <= 1'b0;
          busy <= 1'b1;
          cnt  <= CW'(DW);
        end
      end else if (busy) begin
        rem <= ge ? diff[DW-1:0] : trial[DW-1:0];
        quo <= {quo[DW-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
#(
  parameter int DW = 8,
  parameter int WW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic          wsize,
  input  logic          use_imm,
  input  logic [WW-1:0] rd,
  input  logic [WW-1:0] rs,
  input  logic [DW-1:0] imm,
  input  logic          c_in,
  input  logic          h_in,
  output logic [WW-1:0] result,
  output logic [4:0]    flags,
  output logic          err,
  output logic          done,
  output logic          busy
);

  op_e opc;
  assign opc = op_e'(op);

  logic          legal;
  logic          accept;
  logic [WW-1:0] res_q;
  flags_t        flg_q;
  logic          done_q;
  logic          err_q;

  // operand steering
  logic [DW-1:0] bx, by, br;
  logic          bci, bsub, bc, bh, bv;
  logic [WW-1:0] wx, wy, wr;
  logic          wsub, wc, wh, wv;
  logic [DW-1:0] dec_r;
  logic          dec_c;
  logic [WW-1:0] prod;

  logic          dv_busy, dv_done, dv_ovf;
  logic [DW-1:0] dv_quo, dv_rem;

  logic [WW-1:0] nxt_res;
  flags_t        nxt_flg;

  assign busy   = dv_busy | dv_done;
  assign accept = start & ~busy;

  alu8_legal #(.DW(DW)) u_legal (
    .opc     (opc),
    .wsize   (wsize),
    .use_imm (use_imm),
    .imm     (imm),
    .ok      (legal)
  );

  always_comb begin
    bx   = (opc == OP_NEG) ? '0 : rd[DW-1:0];
    if (opc == OP_NEG)                       by = rd[DW-1:0];
    else if (opc == OP_INC || opc == OP_DEC) by = DW'(1);
    else if (use_imm)                        by = imm;
    else                                     by = rs[DW-1:0];
    bci  = (opc == OP_ADDC || opc == OP_SUBC) ? c_in : 1'b0;
    bsub = (opc == OP_SUB) || (opc == OP_SUBC) || (opc == OP_DEC) ||
           (opc == OP_CMP) || (opc == OP_NEG);
    wx   = rd;
    wy   = (opc == OP_WADD || opc == OP_WSUB) ? {{DW{1'b0}}, imm} : rs;
    wsub = (opc == OP_SUB) || (opc == OP_CMP) || (opc == OP_WSUB);
  end

  alu8_addsub #(.W(DW)) u_add_byte (
    .x   (bx),
    .y   (by),
    .ci  (bci),
    .sub (bsub),
    .r   (br),
    .c_o (bc),
    .h_o (bh),
    .v_o (bv)
  );

  alu8_addsub #(.W(WW)) u_add_word (
    .x   (wx),
    .y   (wy),
    .ci  (1'b0),
    .sub (wsub),
    .r   (wr),
    .c_o (wc),
    .h_o (wh),
    .v_o (wv)
  );

  alu8_bcd #(.DW(DW)) u_bcd (
    .v    (rd[DW-1:0]),
    .c_in (c_in),
    .h_in (h_in),
    .sub  (opc == OP_DAS),
    .r    (dec_r),
    .c_o  (dec_c)
  );

  assign prod = {{DW{1'b0}}, rd[DW-1:0]} * {{DW{1'b0}}, rs[DW-1:0]};

  alu8_div #(.DW(DW)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (accept & legal & (opc == OP_DIV)),
    .dvd   (rd),
    .dvs   (rs[DW-1:0]),
    .busy  (dv_busy),
    .done  (dv_done),
    .ovf   (dv_ovf),
    .quo   (dv_quo),
    .rem   (dv_rem)
  );

  // next result and flags for single-cycle operations
  always_comb begin
    nxt_res = res_q;
    nxt_flg = flg_q;
    case (opc)
      OP_ADD, OP_SUB, OP_CMP: begin
        if (wsize) begin
          if (opc != OP_CMP) nxt_res = wr;
          nxt_flg = '{n: wr[WW-1], z: (wr == '0), v: wv, c: wc, h: wh};
        end else begin
          if (opc != OP_CMP) nxt_res = {{DW{1'b0}}, br};
          nxt_flg = '{n: br[DW-1], z: (br == '0), v: bv, c: bc, h: bh};
        end
      end
      OP_ADDC, OP_SUBC: begin
        nxt_res = {{DW{1'b0}}, br};
        nxt_flg = '{n: br[DW-1], z: (br == '0), v: bv, c: bc, h: bh};
      end
      OP_INC, OP_DEC: begin
        nxt_res   = {{DW{1'b0}}, br};
        nxt_flg.n = br[DW-1];
        nxt_flg.z = (br == '0);
        nxt_flg.v = bv;
      end
      OP_WADD, OP_WSUB: nxt_res = wr;
      OP_DAA, OP_DAS: begin
        nxt_res   = {{DW{1'b0}}, dec_r};
        nxt_flg.n = dec_r[DW-1];
        nxt_flg.z = (dec_r == '0);
        nxt_flg.c = dec_c;
      end
      OP_MUL: nxt_res = prod;
      OP_NEG: begin
        nxt_res   = {{DW{1'b0}}, br};
        nxt_flg.n = br[DW-1];
        nxt_flg.z = (br == '0);
        nxt_flg.v = bv;
        nxt_flg.c = bc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (!legal) begin
          err_q  <= 1'b1;
          done_q <= 1'b1;
        end else if (opc != OP_DIV) begin
          res_q  <= nxt_res;
          flg_q  <= nxt_flg;
          done_q <= 1'b1;
        end
      end
      if (dv_done) begin
        done_q <= 1'b1;
        if (dv_ovf) begin
          flg_q.v <= 1'b1;
        end else begin
          res_q   <= {dv_quo, dv_rem};
          flg_q.n <= dv_quo[DW-1];
          flg_q.z <= (dv_quo == '0);
          flg_q.v <= 1'b0;
        end
      end
    end
  end

  assign result = res_q;
  assign flags  = flg_q;
  assign err    = err_q;
  assign done   = done_q;

endmodule

// File: rtl/alu8_exec_chk.sv
module alu8_exec_chk #(
  parameter int DW = 8,
  parameter int WW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [3:0]    op,
  input logic          use_imm,
  input logic [WW-1:0] rd,
  input logic [WW-1:0] rs,
  input logic [WW-1:0] result,
  input logic [4:0]    flags,
  input logic          err,
  input logic          done,
  input logic          busy
);

  logic issue;
  assign issue = start && !busy;

  assert_err_with_done_R1: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  assert_err_holds_state_R1: assert property (@(posedge clk) disable iff (rst)
    err |-> (result == $past(result) && flags == $past(flags)));

  assert_wadj_keeps_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (issue && (op == 4'd6 || op == 4'd7)) |=> flags == $past(flags));

  assert_div_goes_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (issue && op == 4'd11 && !use_imm && rd[WW-1:DW] < rs[DW-1:0]) |=> busy);

  assert_div_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (issue && op == 4'd11 && !use_imm && rd[WW-1:DW] >= rs[DW-1:0])
      |-> ##2 (done && flags[2]));

  assert_cmp_keeps_result_R10: assert property (@(posedge clk) disable iff (rst)
    (issue && op == 4'd12) |=> result == $past(result));

  assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind alu8_exec alu8_exec_chk #(.DW(DW), .WW(WW)) u_chk (.*);

// File: tb/alu8_exec_tb.sv
module alu8_exec_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic        wsize = 1'b0;
  logic        use_imm = 1'b0;
  logic [15:0] rd = '0;
  logic [15:0] rs = '0;
  logic [7:0]  imm = '0;
  logic        c_in = 1'b0;
  logic        h_in = 1'b0;
  logic [15:0] result;
  logic [4:0]  flags;
  logic        err;
  logic        done;
  logic        busy;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  int exp_res = 0;
  logic [4:0] exp_flg = '0;

  always #4 clk = ~clk;

  alu8_exec u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .wsize(wsize),
    .use_imm(use_imm), .rd(rd), .rs(rs), .imm(imm), .c_in(c_in),
    .h_in(h_in), .result(result), .flags(flags), .err(err),
    .done(done), .busy(busy)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic arith(input int x, input int y, input int ci, input bit sub, input int w,
                       output int r, output bit c, output bit h, output bit v);
    int m, lm, s, hs, sg;
    m  = (1 << w) - 1;
    lm = (1 << (w - 4)) - 1;
    sg = 1 << (w - 1);
    if (!sub) begin
      s = x + y + ci;             c = (s > m);
      hs = (x & lm) + (y & lm) + ci; h = (hs > lm);
    end else begin
      s = x - y - ci;             c = (s < 0);
      hs = (x & lm) - (y & lm) - ci; h = (hs < 0);
    end
    r = s & m;
    if (!sub) v = ((x ^ y) & sg) == 0 && ((x ^ r) & sg) != 0;
    else      v = ((x ^ y) & sg) != 0 && ((x ^ r) & sg) != 0;
  endtask

  function automatic logic [4:0] fl(input int r, input int w, input bit v, input bit c, input bit h);
    return {((r >> (w - 1)) & 1) == 1, r == 0, v, c, h};
  endfunction

  task automatic run(input string rq, input int o, input int ws, input int ui,
                     input int a, input int b, input int im, input int ci, input int hi,
                     input bit poke = 0);
    int nres, lat, r, y8, a8, d, q, lo, hf, adj;
    logic [4:0] nflg;
    bit nerr, ok, c, h, v;
    nres = exp_res; nflg = exp_flg; nerr = 0; lat = 1;
    y8 = ui ? im : (b & 255);
    a8 = a & 255;
    case (o)
      0, 12:         ok = !(ws && ui);
      1:             ok = !ui;
      2, 3, 4, 5, 8, 9, 13: ok = !ws;
      6, 7:          ok = ui && (im == 1 || im == 2);
      10, 11:        ok = !ui;
      default:       ok = 0;
    endcase
    if (!ok) nerr = 1;
    else begin
      case (o)
        0, 1, 12: begin
          if (ws) begin arith(a, b, 0, o != 0, 16, r, c, h, v); nflg = fl(r, 16, v, c, h); end
          else begin    arith(a8, y8, 0, o != 0, 8, r, c, h, v); nflg = fl(r, 8, v, c, h); end
          if (o != 12) nres = r;
        end
        2, 3: begin arith(a8, y8, ci, o == 3, 8, r, c, h, v); nres = r; nflg = fl(r, 8, v, c, h); end
        4, 5: begin
          arith(a8, 1, 0, o == 5, 8, r, c, h, v); nres = r;
          nflg = {fl(r, 8, v, 0, 0) >> 2, exp_flg[1:0]};
        end
        6: nres = (a + im) & 65535;
        7: nres = (a - im) & 65535;
        8, 9: begin
          lo = ((a8 & 15) > 9) || hi;
          hf = (a8 > 153) || ci;
          adj = (hf ? 96 : 0) + (lo ? 6 : 0);
          r = ((o == 8) ? a8 + adj : a8 - adj) & 255;
          nres = r;
          nflg = {((r >> 7) & 1) == 1, r == 0, exp_flg[2], hf == 1, exp_flg[0]};
        end
        10: nres = a8 * (b & 255);
        11: begin
          d = b & 255;
          if (d == 0 || (a >> 8) >= d) begin nflg[2] = 1; lat = 2; end
          else begin
            q = a / d;
            nres = (q << 8) | (a % d);
            nflg = {((q >> 7) & 1) == 1, q == 0, 1'b0, exp_flg[1:0]};
            lat = 10;
          end
        end
        13: begin
          arith(0, a8, 0, 1, 8, r, c, h, v); nres = r;
          nflg = {fl(r, 8, v, c, 0) >> 1, exp_flg[0]};
        end
        default: ;
      endcase
    end
    @(negedge clk);
    op = 4'(o); wsize = ws[0]; use_imm = ui[0]; rd = 16'(a); rs = 16'(b);
    imm = 8'(im); c_in = ci[0]; h_in = hi[0]; start = 1'b1;
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      if (i == 1) start = 1'b0;
      if (poke && i == 3) begin start = 1'b1; op = 4'd0; end
      if (poke && i == 4) begin start = 1'b0; op = 4'(o); end
      chk(rq, "done", int'(done), int'(i == lat));
      chk(rq, "busy", int'(busy), int'(i < lat));
      if (i == lat) begin
        chk(rq, "result", int'(result), nres);
        chk(rq, "flags", int'(flags), int'(nflg));
        chk(rq, "err", int'(err), int'(nerr));
      end
    end
    exp_res = nres;
    exp_flg = nflg;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "reset result", int'(result), 0);
    chk("R12", "reset flags", int'(flags), 0);
    chk("R12", "reset done/err/busy", int'({done, err, busy}), 0);

    run("R2", 0, 0, 0, 16'h003A, 16'h0048, 0, 0, 0);
    run("R2", 0, 0, 1, 16'h00FF, 0, 8'h01, 0, 0);
    run("R2", 0, 1, 0, 16'h0FFF, 16'h0001, 0, 0, 0);
    run("R2", 1, 0, 0, 16'h0010, 16'h0020, 0, 0, 0);
    run("R2", 1, 1, 0, 16'h8000, 16'h0001, 0, 0, 0);
    run("R3", 2, 0, 0, 16'h007F, 16'h0000, 0, 1, 0);
    run("R3", 2, 0, 0, 16'h007F, 16'h0000, 0, 0, 0);
    run("R3", 3, 0, 1, 16'h0000, 0, 8'h00, 1, 0);
    run("R4", 4, 0, 0, 16'h007F, 0, 0, 0, 0);
    run("R4", 5, 0, 0, 16'h0000, 0, 0, 0, 0);
    run("R5", 6, 1, 1, 16'hFFFF, 0, 2, 0, 0);
    run("R5", 7, 1, 1, 16'h0000, 0, 1, 0, 0);
    run("R6", 8, 0, 0, 16'h009A, 0, 0, 0, 0);
    run("R6", 8, 0, 0, 16'h0015, 0, 0, 0, 1);
    run("R6", 9, 0, 0, 16'h008F, 0, 0, 0, 1);
    run("R6", 9, 0, 0, 16'h00F5, 0, 0, 1, 0);
    run("R7", 10, 0, 0, 16'h00FF, 16'h00FF, 0, 0, 0);
    run("R7", 10, 0, 0, 16'h0000, 16'h0012, 0, 0, 0);
    run("R8/R12", 11, 0, 0, 16'h1234, 16'h0056, 0, 0, 0, 1);
    run("R8", 11, 0, 0, 16'h00FF, 16'h0010, 0, 0, 0);
    run("R8", 11, 0, 0, 16'h3FFF, 16'h0040, 0, 0, 0);
    run("R9", 11, 0, 0, 16'h1234, 16'h0000, 0, 0, 0);
    run("R9", 11, 0, 0, 16'h5000, 16'h0040, 0, 0, 0);
    run("R10", 12, 0, 0, 16'h0005, 16'h0005, 0, 0, 0);
    run("R10", 12, 1, 0, 16'h1000, 16'h2000, 0, 0, 0);
    run("R11", 13, 0, 0, 16'h0080, 0, 0, 0, 0);
    run("R11", 13, 0, 0, 16'h0000, 0, 0, 0, 0);
    run("R11", 13, 0, 0, 16'h0001, 0, 0, 0, 0);
    run("R1", 1, 0, 1, 16'h0040, 0, 8'h01, 0, 0);
    run("R1", 0, 1, 1, 16'h0040, 0, 8'h01, 0, 0);
    run("R1", 12, 1, 1, 16'h0040, 0, 8'h01, 0, 0);
    run("R1", 2, 1, 0, 16'h0040, 16'h0001, 0, 0, 0);
    run("R1", 6, 1, 1, 16'h0040, 0, 3, 0, 0);
    run("R1", 7, 1, 0, 16'h0040, 0, 1, 0, 0);
    run("R1", 10, 0, 1, 16'h0040, 0, 2, 0, 0);
    run("R1", 11, 0, 1, 16'h0040, 0, 2, 0, 0);
    run("R1", 15, 0, 0, 16'h0040, 16'h0001, 0, 0, 0);
    run("R2", 0, 0, 0, 16'h0080, 16'h0080, 0, 0, 0);
    repeat (2) @(negedge clk);
    summary();
  end

endmodule